// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers for a clock-control block. A fast system clock oversamples the serial clock and data lines. The slave answers only to its own 7-bit device address. In a write, it acknowledges and discards two header bytes: a command code first, then a byte count. Every data byte after those two goes to the next register in turn, starting at register 0. There is no register addressing inside the transaction.

A read transaction returns the bank in the same fixed order, starting at register 0. The register contents are presented in parallel as one flat vector, with register 0 in the lowest byte. The clock-control logic uses this vector directly. Default values are loaded only by the power-up reset. No bus event reloads them.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal the parameter `DEV_ADDR`. Bit 0 of that byte selects the direction: 0 is write, 1 is read. A byte with any other address gets no acknowledge, and the rest of that transaction leaves the bank unchanged.
- R2: In a write, the first two bytes after the address are acknowledged, and their values are written nowhere.
- R3: Write data bytes go to register 0, then 1, then 2, and so on in strict order. Every data byte is acknowledged.
- R4: After reset the bank reads 0x00, 0x8F, 0x7F, 0xFF, 0x0F, 0x13 and 0x00 for registers 0 to 6.
- R5: Reserved bits always hold 0, whatever value is written. The reserved bits are: register 1 bits 6:4, register 2 bit 7, register 4 bits 7:4, register 5 bits 7:5 and 3:2, and all of register 6.
- R6: A data byte that arrives after register 6 has been written is acknowledged and changes no register.
- R7: A START or STOP condition in the middle of a transaction resets the pointers. The next transaction again treats its first two bytes after the address as header bytes and writes from register 0.
- R8: A read returns register 0, then 1, and so on, MSB first. A master NACK ends the read.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: Register values persist across transactions, including reads and foreign-address traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| reg_bank_o | output | NREG*8 | Register bank, with register n at bits 8n+7:8n |

## Verification
The bench keeps the default bank depth of seven registers, so the reserved-bit layout and the overflow past register 6 are both reached. It sets the device address to 0x52 instead of the default. This shows that matching follows the parameter, and a neighbouring address that differs in one bit then checks rejection. With eight system clocks per SCL quarter period, the two-flop synchronizer delay fits inside each low phase. Every acknowledge and read bit is therefore settled before the master samples it.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2D,
  parameter int         NREG     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] reg_bank_o
);
  localparam int IW = $clog2(NREG + 3);
  localparam logic [IW-1:0] IMAX = IW'(NREG + 2);

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0: wmask = 8'hFF;
      1: wmask = 8'h8F;
      2: wmask = 8'h7F;
      3: wmask = 8'hFF;
      4: wmask = 8'h0F;
      5: wmask = 8'h13;
      default: wmask = 8'h00;
    endcase
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic       in_ack;
  logic [7:0] sh, rd_byte;
  logic [IW-1:0] idx, widx;
  logic [7:0] regs [NREG];

  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;
  wire wr_ok = (idx >= IW'(2)) && (idx < IMAX);
  wire [IW-1:0] idx_nx = (idx == IMAX) ? idx : idx + IW'(1);
  assign widx = idx - IW'(2);

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) rd_byte = regs[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_bank_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sh     <= '0;
      idx    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 0) ? 8'h00 : wmask(i);
    end else if (start) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      in_ack <= 1'b0;
      idx    <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (!in_ack) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != S_RD) sh <= {sh[6:0], sda_s};
        end else if (st == S_RD && sda_s) begin
          st <= S_IDLE;
        end
      end else if (fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          if (st == S_RD) begin
            sda_oe <= ~rd_byte[7];
            sh     <= {rd_byte[6:0], 1'b0};
            idx    <= idx_nx;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          case (st)
            S_ADDR: begin
              if (sh[7:1] == DEV_ADDR) begin
                in_ack <= 1'b1;
                sda_oe <= 1'b1;
                st     <= sh[0] ? S_RD : S_WR;
              end else begin
                st <= S_IDLE;
              end
            end
            S_WR: begin
              in_ack <= 1'b1;
              sda_oe <= 1'b1;
              idx    <= idx_nx;
              for (int i = 0; i < NREG; i++)
                if (wr_ok && widx == IW'(i)) regs[i] <= sh & wmask(i);
            end
            default: begin
              in_ack <= 1'b1;
              sda_oe <= 1'b0;
            end
          endcase
        end else if (st == S_RD) begin
          sda_oe <= ~sh[7];
          sh     <= {sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int NREG = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] reg_bank_o
);
  logic [NREG*8-1:0] rsv_mask, prev_bank;
  logic [NREG-1:0]   chg;
  logic              seen;

  always_comb begin
    rsv_mask = '0;
    for (int i = 0; i < NREG; i++) begin
      case (i)
        1: rsv_mask[i*8 +: 8] = 8'h70;
        2: rsv_mask[i*8 +: 8] = 8'h80;
        4: rsv_mask[i*8 +: 8] = 8'hF0;
        5: rsv_mask[i*8 +: 8] = 8'hEC;
        0, 3: rsv_mask[i*8 +: 8] = 8'h00;
        default: rsv_mask[i*8 +: 8] = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    prev_bank <= reg_bank_o;
    seen      <= rst_n;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chg
    assign chg[g] = prev_bank[g*8 +: 8] != reg_bank_o[g*8 +: 8];
  end

  // R9
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3
  bank_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank_o) |-> !scl_i);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_bank_o & rsv_mask) == '0);

  // R3
  one_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $onehot0(chg));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_bank_o(reg_bank_o)
);

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
  localparam logic [6:0] A = 7'h52;
  localparam int NREG = 7;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] bank;
  wire sda_line = sda_m & ~sda_oe;
  int errs = 0, checks = 0, viol = 0;
  logic [7:0] expb [NREG];
  logic oe_d = 1'b0, scl_d = 1'b1;

  always #5 clk = ~clk;

  cfg_serial_slave #(.DEV_ADDR(A), .NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_bank_o(bank)
  );

  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_d && scl_d) viol++;
    oe_d  <= sda_oe;
    scl_d <= scl_m;
  end

  function automatic logic [7:0] msk(input int i);
    case (i)
      0, 3: msk = 8'hFF;
      1: msk = 8'h8F;
      2: msk = 8'h7F;
      4: msk = 8'h0F;
      5: msk = 8'h13;
      default: msk = 8'h00;
    endcase
  endfunction

  function automatic logic [NREG*8-1:0] exp_bank();
    for (int i = 0; i < NREG; i++) exp_bank[i*8 +: 8] = expb[i];
  endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic set_defaults();
    for (int i = 0; i < NREG; i++) expb[i] = (i == 0) ? 8'h00 : msk(i);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; wq();
    set_defaults();
    check("R4 defaults", 64'(bank), 64'(exp_bank()));
    check("R4 sda idle", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_full_write();
    logic ack;
    logic [7:0] d [NREG];
    d = '{8'hC3, 8'hFF, 8'hFF, 8'h5A, 8'hFF, 8'hFF, 8'hE7};
    i2c_start();
    send({A, 1'b0}, ack); check("R1 address ack", 64'(ack), 64'd1);
    send(8'hA5, ack); check("R2 command ack", 64'(ack), 64'd1);
    send(8'h3C, ack); check("R2 count ack", 64'(ack), 64'd1);
    for (int i = 0; i < NREG; i++) begin
      send(d[i], ack); check("R3 data ack", 64'(ack), 64'd1);
      expb[i] = d[i] & msk(i);
    end
    i2c_stop(); wq();
    check("R3 R5 sequential fill with reserved zero", 64'(bank), 64'(exp_bank()));
  endtask

  task automatic t_read(input logic [7:0] nbytes);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send({A, 1'b1}, ack); check("R1 read address ack", 64'(ack), 64'd1);
    for (int i = 0; i < int'(nbytes); i++) begin
      recv(b, i != int'(nbytes) - 1);
      check("R8 read byte", 64'(b), 64'(expb[i]));
    end
    i2c_stop(); wq();
    check("R8 released after NACK", 64'(sda_oe), 64'd0);
    check("R10 bank kept after read", 64'(bank), 64'(exp_bank()));
  endtask

  task automatic t_wrong_addr();
    logic ack;
    i2c_start();
    send({A ^ 7'h01, 1'b0}, ack); check("R1 foreign address nack", 64'(ack), 64'd0);
    send(8'h00, ack); send(8'h00, ack); send(8'h00, ack); send(8'h00, ack);
    i2c_stop(); wq();
    check("R1 R10 foreign traffic ignored", 64'(bank), 64'(exp_bank()));
  endtask

  task automatic t_overflow();
    logic ack;
    i2c_start();
    send({A, 1'b0}, ack); send(8'h00, ack); send(8'h00, ack);
    for (int i = 0; i < NREG; i++) begin
      send(8'h00, ack); expb[i] = 8'h00;
    end
    send(8'h77, ack); check("R6 extra byte ack", 64'(ack), 64'd1);
    send(8'h77, ack); check("R6 second extra byte ack", 64'(ack), 64'd1);
    i2c_stop(); wq();
    check("R6 extra bytes discarded", 64'(bank), 64'(exp_bank()));
  endtask

  task automatic t_restart();
    logic ack;
    i2c_start();
    send({A, 1'b0}, ack); send(8'h11, ack); send(8'h22, ack); send(8'h9A, ack);
    i2c_start();
    send({A, 1'b0}, ack); send(8'h44, ack); send(8'h55, ack); send(8'h21, ack);
    send(8'h8B, ack);
    i2c_stop(); wq();
    expb[0] = 8'h21; expb[1] = 8'h8B & msk(1);
    check("R7 repeated start restarts at headers", 64'(bank), 64'(exp_bank()));
    i2c_start();
    send({A, 1'b0}, ack); send(8'h66, ack);
    i2c_stop();
    i2c_start();
    send({A, 1'b0}, ack); send(8'h01, ack); send(8'h02, ack); send(8'h66, ack);
    i2c_stop(); wq();
    expb[0] = 8'h66;
    check("R7 stop after one header restarts", 64'(bank), 64'(exp_bank()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_full_write();
    t_read(8'd7);
    t_wrong_addr();
    t_overflow();
    t_restart();
    t_read(8'd3);
    t_reset();
    check("R9 drive changes only with SCL low", 64'(viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule